// File: doc/BRIEF.md
# Flash Read-Configuration Write Sequencer

This block is a small bus master that switches an external NOR flash from asynchronous reads to synchronous burst reads. The flash takes its read-configuration word on the address lines, not the data lines. The block builds that address from a configuration value. It then issues a setup write followed by a confirm write to that address, waiting on a ready handshake for each one. When the board carries two flash devices on a 16-bit bus, the block repeats the same pair of writes at the second device's base address.

The sequence starts by itself after reset. It can also be started again with a start pulse whenever the block is not busy. The block also exposes the CAS-latency code held in the configuration value, so the memory controller's own configuration register can be loaded with the same code. If the memory clock is flagged as too fast for synchronous operation, the block refuses to run and raises an error flag.

Top module: `flashcfg_seq`

## Requirements
- R1: Leaving reset arms an automatic launch. The first clock edge after reset is released starts the sequence, and wr_o is high in the cycle that follows. From idle or done, a start_i pulse also launches the sequence.
- R2: For each device, the block issues two writes to the same address. The first write carries command byte 0x60 and the second carries 0x03. On a 16-bit bus, data bits 31:16 are zero.
- R3: The write address is the configuration value captured at launch, shifted left by 1 when wide_bus_i=0 and by 2 when wide_bus_i=1. For example, 0x25C2 gives 0x4B84 on a 16-bit bus and 0x9708 on a 32-bit bus.
- R4: On a 32-bit bus, each data word carries the command in both halfwords: 0x00600060, then 0x00030003.
- R5: When dual_dev_i=1 and wide_bus_i=0 at launch, a second pair of writes follows at the same offset plus 0x01000000. On a 32-bit bus, dual_dev_i has no effect.
- R6: While wr_o is high and ready_i is low, wr_o, addr_o and data_o hold their values on the next cycle. A write completes only at a clock edge where ready_i is sampled high.
- R7: busy_o is high exactly while a write is outstanding. It is never high together with done_o. A start_i pulse while busy does not change the sequence of writes.
- R8: done_o rises in the cycle after the final write is acknowledged. No writes follow until the next launch, and a successful launch clears done_o.
- R9: cas_field_o equals bits 13:11 of cfg_value_i. This is the CAS latency minus one: 0b100 means 5 clocks.
- R10: A launch while clk_fast_i=1 issues no writes and sets err_o. The state of done_o is left as it was. The next launch with clk_fast_i=0 clears err_o.
- R11: A synchronous active-low reset drives wr_o, busy_o, done_o and err_o low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch request, honoured when not busy |
| cfg_value_i | input | 16 | Read-configuration value for the flash |
| wide_bus_i | input | 1 | 1 selects a 32-bit bus, 0 a 16-bit bus |
| dual_dev_i | input | 1 | Two devices on a 16-bit bus |
| clk_fast_i | input | 1 | Memory clock above the synchronous limit |
| ready_i | input | 1 | Bus acknowledges the current write |
| addr_o | output | 26 | Write address carrying the configuration |
| data_o | output | 32 | Write data (command bytes) |
| wr_o | output | 1 | Write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Launch refused because the clock is too fast |
| cas_field_o | output | 3 | Latency-minus-one code for the controller |

## Verification
The assertions check on every cycle the properties that hold at any moment. The strobe, address and data stay stable while ready is low. Busy and done are never high together. Done rises only right after an acknowledged write. The setup command is always followed by its confirm at the same address. An error never coexists with a write. Only the bench's scenarios show the behaviours that depend on the settings captured at launch: the shift chosen by bus width, the duplication into both halfwords, the second-device pass and its suppression on a wide bus. The same holds for the automatic launch after reset and for start pulses being ignored mid-sequence.

// File: rtl/flashcfg_pkg.sv
// Shared types and constants for the flash configuration sequencer.
// Assumes command bytes fit in one halfword of the data bus.
package flashcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_W1_D0 = 3'd1,
        ST_W2_D0 = 3'd2,
        ST_W1_D1 = 3'd3,
        ST_W2_D1 = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'h03;

endpackage

// File: rtl/flashcfg_fsm.sv
// Sequencing state machine: launches on reset release or start, walks the
// write states on each acknowledged write, captures the launch settings.
// Assumes ready_i is only meaningful while a write state is active.
module flashcfg_fsm
    import flashcfg_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fast_i,
    input  logic             wide_i,
    input  logic             dual_i,
    input  logic             ready_i,
    input  logic [CFG_W-1:0] cfg_i,
    output seq_state_t       state_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             wide_o,
    output logic             err_o
);

    seq_state_t state_q, state_d;
    logic       pend_q;
    logic       dual_q;
    logic       launch;
    logic       go;

    // Launch request is honoured only when no write is outstanding
    always_comb begin
        launch = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && (pend_q || start_i);
        go     = launch && !fast_i;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_DONE: if (go) state_d = ST_W1_D0;
            ST_W1_D0: if (ready_i) state_d = ST_W2_D0;
            ST_W2_D0: if (ready_i) state_d = (dual_q && !wide_o) ? ST_W1_D1 : ST_DONE;
            ST_W1_D1: if (ready_i) state_d = ST_W2_D1;
            ST_W2_D1: if (ready_i) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, pending-launch flag, error flag and captured settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b1;
            err_o   <= 1'b0;
            cfg_o   <= '0;
            wide_o  <= 1'b0;
            dual_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                pend_q <= 1'b0;
                err_o  <= fast_i;
            end
            if (go) begin
                cfg_o  <= cfg_i;
                wide_o <= wide_i;
                dual_q <= dual_i;
            end
        end
    end

    assign state_o = state_q;

    // R10
    err_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (state_q == ST_IDLE || state_q == ST_DONE));

    // R5
    wide_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_W1_D1) |-> !wide_o);

endmodule

// File: rtl/flashcfg_fmt.sv
// Bus formatter: places the captured configuration on the address lines and
// the command byte on the data lines for the current write state.
// Assumes ADDR_W is wide enough for the value shifted by 2 plus the base.
module flashcfg_fmt
    import flashcfg_pkg::*;
#(
    parameter int          CFG_W     = 16,
    parameter int          ADDR_W    = 26,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DEV1_BASE = 32'h0100_0000
) (
    input  seq_state_t        state_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int HALF_W = DATA_W / 2;

    logic [ADDR_W-1:0] offset;
    logic [HALF_W-1:0] cmd;
    logic              second_dev;
    logic              setup_phase;

    // Address: value shifted by bus width, relocated for the second device
    always_comb begin
        second_dev  = (state_i == ST_W1_D1) || (state_i == ST_W2_D1);
        setup_phase = (state_i == ST_W1_D0) || (state_i == ST_W1_D1);
        offset = wide_i ? ADDR_W'({cfg_i, 2'b00}) : ADDR_W'({cfg_i, 1'b0});
        addr_o = second_dev ? (offset + DEV1_BASE[ADDR_W-1:0]) : offset;
    end

    // Data: command byte, copied to both halfwords on a wide bus
    always_comb begin
        cmd    = HALF_W'(setup_phase ? CMD_SETUP : CMD_CONFIRM);
        data_o = wide_i ? {cmd, cmd} : {{HALF_W{1'b0}}, cmd};
    end

endmodule

// File: rtl/flashcfg_seq.sv
// Top of the flash read-configuration sequencer. Issues setup/confirm write
// pairs whose address carries the configuration value; exposes the latency
// code. Assumes the bus holds ready_i low until it takes a write.
module flashcfg_seq
    import flashcfg_pkg::*;
#(
    parameter int CFG_W   = 16,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32,
    parameter int LAT_LSB = 11,
    parameter int LAT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CFG_W-1:0]  cfg_value_i,
    input  logic              wide_bus_i,
    input  logic              dual_dev_i,
    input  logic              clk_fast_i,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [LAT_W-1:0]  cas_field_o
);

    seq_state_t       state;
    logic [CFG_W-1:0] cfg_cap;
    logic             wide_cap;

    flashcfg_fsm #(.CFG_W(CFG_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .fast_i  (clk_fast_i),
        .wide_i  (wide_bus_i),
        .dual_i  (dual_dev_i),
        .ready_i (ready_i),
        .cfg_i   (cfg_value_i),
        .state_o (state),
        .cfg_o   (cfg_cap),
        .wide_o  (wide_cap),
        .err_o   (err_o)
    );

    flashcfg_fmt #(.CFG_W(CFG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fmt (
        .state_i (state),
        .cfg_i   (cfg_cap),
        .wide_i  (wide_cap),
        .addr_o  (addr_o),
        .data_o  (data_o)
    );

    // Strobe and status decoded from the sequencing state
    always_comb begin
        wr_o   = (state == ST_W1_D0) || (state == ST_W2_D0) ||
                 (state == ST_W1_D1) || (state == ST_W2_D1);
        busy_o = wr_o;
        done_o = (state == ST_DONE);
    end

    // Latency-minus-one code lifted from the configuration value
    assign cas_field_o = cfg_value_i[LAT_LSB +: LAT_W];

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && !ready_i) |=> (wr_o && $stable(addr_o) && $stable(data_o)));

    // R2
    cmd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && ready_i && data_o[7:0] == 8'h60) |=>
        (wr_o && data_o[7:0] == 8'h03 && $stable(addr_o)));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_o && ready_i));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !wr_o);

endmodule

// File: tb/flashcfg_seq_test.sv
// Bench: behavioural reference model (queue of expected writes) compared on
// every clock, plus named scenario checks.
module flashcfg_seq_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cfg_value_i = 16'h25C2;
    logic        wide_bus_i = 1'b0;
    logic        dual_dev_i = 1'b0;
    logic        clk_fast_i = 1'b0;
    logic        ready_i = 1'b1;
    logic [25:0] addr_o;
    logic [31:0] data_o;
    logic        wr_o, busy_o, done_o, err_o;
    logic [2:0]  cas_field_o;

    int errors = 0;
    int checks = 0;
    int drv_cyc = 0;
    int ready_mode = 0;
    bit model_ok = 1'b0;

    int unsigned q_addr[$];
    int unsigned q_data[$];
    bit m_done = 1'b0;
    bit m_err = 1'b0;
    bit m_pend = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flashcfg_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_value_i(cfg_value_i),
        .wide_bus_i(wide_bus_i), .dual_dev_i(dual_dev_i), .clk_fast_i(clk_fast_i),
        .ready_i(ready_i), .addr_o(addr_o), .data_o(data_o), .wr_o(wr_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .cas_field_o(cas_field_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each clock edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            q_addr.delete(); q_data.delete();
            m_done = 0; m_err = 0; m_pend = 1; model_ok = 1;
        end else if (q_addr.size() > 0) begin
            if (ready_i) begin
                void'(q_addr.pop_front()); void'(q_data.pop_front());
                if (q_addr.size() == 0) m_done = 1;
            end
        end else if (m_pend || start_i) begin
            m_pend = 0;
            m_err = clk_fast_i;
            if (!clk_fast_i) begin
                int unsigned off, d1, d2;
                m_done = 0;
                off = wide_bus_i ? (int'(cfg_value_i) << 2) : (int'(cfg_value_i) << 1);
                d1 = wide_bus_i ? 32'h0060_0060 : 32'h60;
                d2 = wide_bus_i ? 32'h0003_0003 : 32'h03;
                q_addr.push_back(off); q_data.push_back(d1);
                q_addr.push_back(off); q_data.push_back(d2);
                if (dual_dev_i && !wide_bus_i) begin
                    q_addr.push_back(off + 32'h0100_0000); q_data.push_back(d1);
                    q_addr.push_back(off + 32'h0100_0000); q_data.push_back(d2);
                end
            end
        end
    end

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (model_ok) begin
            chk("R6 strobe", {31'd0, wr_o}, {31'd0, q_addr.size() > 0});
            chk("R7 busy", {31'd0, busy_o}, {31'd0, q_addr.size() > 0});
            chk("R8 done", {31'd0, done_o}, {31'd0, m_done});
            chk("R10 err", {31'd0, err_o}, {31'd0, m_err});
            chk("R9 cas", {29'd0, cas_field_o}, {29'd0, cfg_value_i[13:11]});
            if (q_addr.size() > 0 && wr_o) begin
                chk("R3 R5 addr", {6'd0, addr_o}, q_addr[0]);
                chk("R2 R4 data", data_o, q_data[0]);
            end
        end
    end

    task automatic tick(input logic st);
        @(negedge clk); #1;
        start_i = st;
        drv_cyc++;
        ready_i = (ready_mode == 0) ? 1'b1 : ((drv_cyc % 3) != 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        run(3);
        chk("R11 wr", {31'd0, wr_o}, 32'd0);
        chk("R11 busy", {31'd0, busy_o}, 32'd0);
        chk("R11 done", {31'd0, done_o}, 32'd0);
        chk("R11 err", {31'd0, err_o}, 32'd0);
        // R1: automatic launch after reset, 16-bit single device
        @(negedge clk); #1; rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1 auto launch", {31'd0, wr_o}, 32'd1);
        chk("R3 addr 16b", {6'd0, addr_o}, 32'h4B84);
        run(6);
        chk("R8 done after seq", {31'd0, done_o}, 32'd1);

        // R4: wide bus with stalling ready
        ready_mode = 1; wide_bus_i = 1'b1;
        tick(1'b1); run(12);
        chk("R8 done wide", {31'd0, done_o}, 32'd1);

        // R5: dual devices on 16-bit bus, faster clock value
        wide_bus_i = 1'b0; dual_dev_i = 1'b1; cfg_value_i = 16'h35C2;
        tick(1'b1); run(3);
        // R7: start pulse mid-sequence ignored
        tick(1'b1); tick(1'b1); run(14);

        // R5: dual flag has no effect on a wide bus
        wide_bus_i = 1'b1;
        tick(1'b1); run(10);

        // R10: launch refused above the clock limit, then cleared
        clk_fast_i = 1'b1;
        tick(1'b1); run(2);
        chk("R10 err set", {31'd0, err_o}, 32'd1);
        chk("R10 no write", {31'd0, wr_o}, 32'd0);
        clk_fast_i = 1'b0; wide_bus_i = 1'b0; dual_dev_i = 1'b0; cfg_value_i = 16'h25C2;
        tick(1'b1); run(10);
        chk("R10 err cleared", {31'd0, err_o}, 32'd0);

        // R11: reset mid-sequence, then automatic relaunch (R1)
        ready_mode = 0; dual_dev_i = 1'b1;
        tick(1'b1); ready_mode = 1; run(1);
        @(negedge clk); #1; rst_n = 1'b0;
        run(1);
        chk("R11 mid wr", {31'd0, wr_o}, 32'd0);
        chk("R11 mid done", {31'd0, done_o}, 32'd0);
        @(negedge clk); #1; rst_n = 1'b1;
        run(16);
        chk("R1 relaunch done", {31'd0, done_o}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule